// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block chooses which of three clocks drives the system clock. The three candidates are the always-running internal oscillator, an external oscillator, and the output of a frequency multiplier. Software writes a single 16-bit control word. That word requests a source, enables the external oscillator and the multiplier, and picks the multiplier's input and factor. The same word reads back the source that is really running, which may differ from the one requested. The oscillators and the multiplier are outside this block. Here they appear only as their clock inputs and their ready inputs.

A request is honoured only when its target is enabled and reports ready. Until then the old source keeps running and a pending bit stays set. When the switch happens, a handover stage synchronised to each clock shuts off the old clock on its own falling edge. Only after that does it let the new clock through, also on its own falling edge. As a result the system clock never carries a clipped pulse. The control logic runs on the internal oscillator, and the ready inputs are taken to be synchronous to it.

The block also guards against unsafe configuration. The multiplier's input and factor are frozen while the multiplier is on. Neither the multiplier nor the oscillator feeding it can be turned off while that path is in use. A multiplier setting whose nominal output would exceed the ceiling is flagged as invalid.

Top module: `sysclk_switch`

## Requirements
- R1: After reset, the control word reads as all zeros, the status reports the internal source, and the system clock runs at the internal oscillator's period.
- R2: Control word layout, taking effect one control clock after the write:
  - [1:0] requested source: 0 internal, 1 external, 2 multiplier. A write of 3 leaves the field unchanged.
  - [3:2] read-only active source, using the same codes.
  - [4] external oscillator enable.
  - [5] multiplier enable.
  - [7:6] multiplier input: 0 internal/2, 1 external, 2 external/2. A write of 3 leaves the field unchanged.
  - [11:8] factor code: factor = code+2, and code 15 also gives 16.
  - [12] external ready (read-only).
  - [13] multiplier ready (read-only).
  - [14] invalid flag.
  - [15] pending.
- R3: A request for the external source is held, and the status does not change, until the external enable and external ready are both set.
- R4: A request for the multiplier is held until the multiplier enable and multiplier ready are both set.
- R5: Once a held request may proceed, the status field reads the new source within 16 control clocks, and the system clock then runs at that source's period. Multiplier active reads as 0x0008 under mask 0x000C.
- R6: The invalid flag is set exactly when the multiplier input frequency times the factor exceeds 72 MHz, with both oscillators at 8 MHz.
- R7: Writes to the multiplier input and factor fields are ignored while the multiplier enable is set. This includes the write that clears it.
- R8: Clearing the multiplier enable is ignored while the multiplier is the active source. Clearing the external enable is ignored while the external source is active, or while the multiplier is active and takes its input from the external oscillator.
- R9: No high or low phase of the system clock is shorter than the shortest half period among the three sources, including across switches.
- R10: The pending bit is set while the requested source differs from the active source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_int_clk | input | 1 | Internal oscillator clock; also clocks the control logic |
| osc_ext_clk | input | 1 | External oscillator clock |
| pll_clk | input | 1 | Multiplier output clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_rdy | input | 1 | External oscillator stable |
| pll_rdy | input | 1 | Multiplier locked |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read data including status |
| sys_clk | output | 1 | Selected system clock |

## Verification
Register fields and the invalid flag change one control clock after the write edge. The bench compares them against its own model on every falling edge of the control clock. A switch crosses into the old clock's domain, then the new clock's domain, then back. For that reason the status is polled for up to 16 control clocks rather than expected on one cycle. The output period is measured only after the status has settled. Held requests are observed for 30 control clocks to show that nothing moves. Every edge of the system clock is timed throughout the run to catch a clipped phase.

// File: rtl/sclk_pkg.sv
`timescale 1ns/1ps
package sclk_pkg;
  localparam int NUM_SRC = 3;
  localparam int REG_W   = 16;
  localparam int MUL_W   = 4;

  localparam logic [1:0] SRC_INT  = 2'd0;
  localparam logic [1:0] SRC_EXT  = 2'd1;
  localparam logic [1:0] SRC_PLL  = 2'd2;
  localparam logic [1:0] SRC_RSVD = 2'd3;

  localparam logic [1:0] PIN_INT_HALF = 2'd0;
  localparam logic [1:0] PIN_EXT      = 2'd1;
  localparam logic [1:0] PIN_EXT_HALF = 2'd2;
  localparam logic [1:0] PIN_RSVD     = 2'd3;

  localparam int SEL_LSB     = 0;
  localparam int STAT_LSB    = 2;
  localparam int EXT_ON_BIT  = 4;
  localparam int PLL_ON_BIT  = 5;
  localparam int PSRC_LSB    = 6;
  localparam int MUL_LSB     = 8;
  localparam int EXT_RDY_BIT = 12;
  localparam int PLL_RDY_BIT = 13;
  localparam int BAD_BIT     = 14;
  localparam int PEND_BIT    = 15;

  // factor = code + 2, saturating at 16
  function automatic int mul_factor(input logic [MUL_W-1:0] code);
    if (code == '1) return 16;
    return int'(code) + 2;
  endfunction

  function automatic int pll_in_khz(input logic [1:0] psrc, input int int_khz,
                                    input int ext_khz);
    case (psrc)
      PIN_EXT:      return ext_khz;
      PIN_EXT_HALF: return ext_khz / 2;
      default:      return int_khz / 2;
    endcase
  endfunction

  function automatic int pll_out_khz(input logic [1:0] psrc, input logic [MUL_W-1:0] code,
                                     input int int_khz, input int ext_khz);
    return pll_in_khz(psrc, int_khz, ext_khz) * mul_factor(code);
  endfunction

  function automatic logic psrc_uses_ext(input logic [1:0] psrc);
    return (psrc == PIN_EXT) || (psrc == PIN_EXT_HALF);
  endfunction

  function automatic logic [NUM_SRC-1:0] src_onehot(input logic [1:0] s);
    case (s)
      SRC_EXT: return 3'b010;
      SRC_PLL: return 3'b100;
      default: return 3'b001;
    endcase
  endfunction

  function automatic logic [1:0] src_of(input logic [NUM_SRC-1:0] v);
    case (v)
      3'b010:  return SRC_EXT;
      3'b100:  return SRC_PLL;
      default: return SRC_INT;
    endcase
  endfunction
endpackage

// File: rtl/sclk_cfg_regs.sv
`timescale 1ns/1ps
module sclk_cfg_regs
  import sclk_pkg::*;
#(
  parameter int INT_KHZ = 8000,
  parameter int EXT_KHZ = 8000,
  parameter int MAX_KHZ = 72000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic [1:0]       issued,
  input  logic [1:0]       active,
  output logic [1:0]       req_sel,
  output logic             ext_on,
  output logic             pll_on,
  output logic [1:0]       pll_src,
  output logic [MUL_W-1:0] mul_code,
  output logic             cfg_bad
);
  logic [1:0]       w_sel;
  logic [1:0]       w_src;
  logic [MUL_W-1:0] w_mul;
  logic             pll_busy;
  logic             ext_busy;
  logic             unused_bits;

  assign w_sel = wdata[SEL_LSB +: 2];
  assign w_src = wdata[PSRC_LSB +: 2];
  assign w_mul = wdata[MUL_LSB +: MUL_W];
  assign unused_bits = ^{wdata[STAT_LSB +: 2], wdata[REG_W-1:EXT_RDY_BIT]};

  // a source counts as in use once issued to the mux or reported active
  assign pll_busy = (issued == SRC_PLL) || (active == SRC_PLL);
  assign ext_busy = (issued == SRC_EXT) || (active == SRC_EXT) ||
                    (pll_busy && psrc_uses_ext(pll_src));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sel  <= SRC_INT;
      ext_on   <= 1'b0;
      pll_on   <= 1'b0;
      pll_src  <= PIN_INT_HALF;
      mul_code <= '0;
    end else if (we) begin
      if (w_sel != SRC_RSVD) req_sel <= w_sel;
      if (wdata[EXT_ON_BIT])  ext_on <= 1'b1;
      else if (!ext_busy)     ext_on <= 1'b0;
      if (wdata[PLL_ON_BIT])  pll_on <= 1'b1;
      else if (!pll_busy)     pll_on <= 1'b0;
      if (!pll_on) begin
        if (w_src != PIN_RSVD) pll_src <= w_src;
        mul_code <= w_mul;
      end
    end
  end

  assign cfg_bad = pll_out_khz(pll_src, mul_code, INT_KHZ, EXT_KHZ) > MAX_KHZ;

  a_r7_pll_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pll_on |=> ($stable(pll_src) && $stable(mul_code)));
  a_r8_pll_kept_on: assert property (@(posedge clk) disable iff (!rst_n)
    (active == SRC_PLL) |=> pll_on);
  a_r8_ext_kept_on: assert property (@(posedge clk) disable iff (!rst_n)
    (active == SRC_EXT) |=> ext_on);
endmodule

// File: rtl/sclk_switch_ctl.sv
`timescale 1ns/1ps
module sclk_switch_ctl
  import sclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         req_sel,
  input  logic               ext_ok,
  input  logic               pll_ok,
  input  logic [NUM_SRC-1:0] en_raw,
  output logic [1:0]         issued,
  output logic [1:0]         active,
  output logic [NUM_SRC-1:0] go,
  output logic               switch_start
);
  logic [NUM_SRC-1:0] en_s1;
  logic [NUM_SRC-1:0] en_s2;
  logic               tgt_ok;
  logic               idle;

  always_comb begin
    case (req_sel)
      SRC_EXT: tgt_ok = ext_ok;
      SRC_PLL: tgt_ok = pll_ok;
      default: tgt_ok = 1'b1;
    endcase
  end

  // a new switch starts only once the previous one has fully landed
  assign idle         = (en_s2 == src_onehot(issued));
  assign switch_start = (req_sel != issued) && tgt_ok && idle;
  assign go           = src_onehot(issued);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1  <= 3'b001;
      en_s2  <= 3'b001;
      issued <= SRC_INT;
      active <= SRC_INT;
    end else begin
      en_s1 <= en_raw;
      en_s2 <= en_s1;
      if (switch_start) issued <= req_sel;
      if ($onehot(en_s2)) active <= src_of(en_s2);
    end
  end

  a_r3_ext_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
    (issued == SRC_EXT && $past(issued) != SRC_EXT) |-> $past(ext_ok));
  a_r4_pll_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
    (issued == SRC_PLL && $past(issued) != SRC_PLL) |-> $past(pll_ok));
  a_r5_status_tracks_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (active != $past(active)) |-> (active == $past(issued)));
  a_r9_single_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_s2));
endmodule

// File: rtl/sclk_glitchless_mux.sv
`timescale 1ns/1ps
module sclk_glitchless_mux
  import sclk_pkg::*;
(
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] clks,
  input  logic [NUM_SRC-1:0] go,
  output logic [NUM_SRC-1:0] en,
  output logic               clk_out
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic s1;
    logic s2;
    logic others_on;

    assign others_on = |(en & ~(NUM_SRC'(1) << i));

    // stage one samples the request in this clock's own domain
    always_ff @(posedge clks[i] or negedge rst_n) begin
      if (!rst_n) s1 <= 1'(i == 0);
      else        s1 <= go[i] & ~others_on;
    end

    // stage two opens or closes the gate while this clock is low
    always_ff @(negedge clks[i] or negedge rst_n) begin
      if (!rst_n) s2 <= 1'(i == 0);
      else        s2 <= s1;
    end

    assign en[i] = s2;
  end

  assign clk_out = |(clks & en);
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch
  import sclk_pkg::*;
#(
  parameter int INT_KHZ = 8000,
  parameter int EXT_KHZ = 8000,
  parameter int MAX_KHZ = 72000
) (
  input  logic             osc_int_clk,
  input  logic             osc_ext_clk,
  input  logic             pll_clk,
  input  logic             rst_n,
  input  logic             ext_rdy,
  input  logic             pll_rdy,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             sys_clk
);
  logic [1:0]         req_sel;
  logic               ext_on;
  logic               pll_on;
  logic [1:0]         pll_src;
  logic [MUL_W-1:0]   mul_code;
  logic               cfg_bad;
  logic [1:0]         issued;
  logic [1:0]         active;
  logic [NUM_SRC-1:0] go;
  logic [NUM_SRC-1:0] gate_en;
  logic               switch_start;
  logic               unused_evt;

  sclk_cfg_regs #(.INT_KHZ(INT_KHZ), .EXT_KHZ(EXT_KHZ), .MAX_KHZ(MAX_KHZ)) u_regs (
    .clk(osc_int_clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .issued(issued), .active(active), .req_sel(req_sel), .ext_on(ext_on),
    .pll_on(pll_on), .pll_src(pll_src), .mul_code(mul_code), .cfg_bad(cfg_bad)
  );

  sclk_switch_ctl u_ctl (
    .clk(osc_int_clk), .rst_n(rst_n), .req_sel(req_sel),
    .ext_ok(ext_on & ext_rdy), .pll_ok(pll_on & pll_rdy), .en_raw(gate_en),
    .issued(issued), .active(active), .go(go), .switch_start(switch_start)
  );

  sclk_glitchless_mux u_mux (
    .rst_n(rst_n), .clks({pll_clk, osc_ext_clk, osc_int_clk}), .go(go),
    .en(gate_en), .clk_out(sys_clk)
  );

  assign unused_evt = switch_start;

  always_comb begin
    cfg_rdata                       = '0;
    cfg_rdata[SEL_LSB +: 2]         = req_sel;
    cfg_rdata[STAT_LSB +: 2]        = active;
    cfg_rdata[EXT_ON_BIT]           = ext_on;
    cfg_rdata[PLL_ON_BIT]           = pll_on;
    cfg_rdata[PSRC_LSB +: 2]        = pll_src;
    cfg_rdata[MUL_LSB +: MUL_W]     = mul_code;
    cfg_rdata[EXT_RDY_BIT]          = ext_rdy;
    cfg_rdata[PLL_RDY_BIT]          = pll_rdy;
    cfg_rdata[BAD_BIT]              = cfg_bad;
    cfg_rdata[PEND_BIT]             = (req_sel != active);
  end

  a_r10_pending_flag: assert property (@(posedge osc_int_clk) disable iff (!rst_n)
    (req_sel == active) |-> !cfg_rdata[PEND_BIT]);
endmodule

// File: tb/sim_sysclk_switch.sv
`timescale 1ns/1ps
module sim_sysclk_switch;
  logic        clk_i = 1'b0;
  logic        clk_e = 1'b0;
  logic        clk_p = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_rdy = 1'b0;
  logic        pll_rdy = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        sys_clk;

  int total = 0;
  int bad = 0;
  int m_sel = 0, m_ext = 0, m_pll = 0, m_src = 0, m_mul = 0, m_use = 0;
  bit cmp_on = 0;
  bit mon_on = 0;
  real last_edge = 0.0;
  real min_pulse = 1.0e9;

  always #10 clk_i = ~clk_i;  // 50 MHz internal / control clock
  always #15 clk_e = ~clk_e;
  always #4  clk_p = ~clk_p;

  sysclk_switch u0 (
    .osc_int_clk(clk_i), .osc_ext_clk(clk_e), .pll_clk(clk_p), .rst_n(rst_n),
    .ext_rdy(ext_rdy), .pll_rdy(pll_rdy), .cfg_we(we), .cfg_wdata(wdata),
    .cfg_rdata(rdata), .sys_clk(sys_clk)
  );

  function automatic logic [15:0] mk(int sel, int ext, int pll, int src, int mul);
    logic [15:0] v;
    v = 16'h0;
    v[1:0] = sel[1:0];
    v[4] = ext[0];
    v[5] = pll[0];
    v[7:6] = src[1:0];
    v[11:8] = mul[3:0];
    return v;
  endfunction

  function automatic int exp_bad(int src, int mul);
    int f;
    int fin;
    f = (mul >= 14) ? 16 : mul + 2;
    fin = (src == 1) ? 8000 : 4000;
    return (fin * f > 72000) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(logic [15:0] v);
    @(negedge clk_i);
    we = 1'b1;
    wdata = v;
    @(negedge clk_i);
    we = 1'b0;
  endtask

  task automatic wait_status(int expv, string req);
    int n;
    n = 0;
    while (int'(rdata[3:2]) != expv && n < 16) begin
      @(negedge clk_i);
      n++;
    end
    check(req, int'(rdata[3:2]), expv);
  endtask

  task automatic measure(real expp, string req);
    real t0;
    real t1;
    @(posedge sys_clk);
    t0 = $realtime;
    @(posedge sys_clk);
    t1 = $realtime;
    total++;
    if ((t1 - t0) < expp - 0.01 || (t1 - t0) > expp + 0.01) begin
      bad++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", req, t1 - t0, expp);
    end
  endtask

  // reference model of the writable fields
  always @(posedge clk_i) begin : model
    int o_pll;
    int o_src;
    if (!rst_n) begin
      m_sel = 0; m_ext = 0; m_pll = 0; m_src = 0; m_mul = 0;
    end else if (we) begin
      o_pll = m_pll;
      o_src = m_src;
      if (wdata[1:0] != 2'd3) m_sel = int'(wdata[1:0]);
      if (wdata[4]) m_ext = 1;
      else if (!(m_use == 1 || (m_use == 2 && (o_src == 1 || o_src == 2)))) m_ext = 0;
      if (wdata[5]) m_pll = 1;
      else if (m_use != 2) m_pll = 0;
      if (o_pll == 0) begin
        if (wdata[7:6] != 2'd3) m_src = int'(wdata[7:6]);
        m_mul = int'(wdata[11:8]);
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_n && cmp_on) begin
      check("R2 sel field", int'(rdata[1:0]), m_sel);
      check("R8 ext enable", int'(rdata[4]), m_ext);
      check("R8 pll enable", int'(rdata[5]), m_pll);
      check("R7 pll input", int'(rdata[7:6]), m_src);
      check("R7 factor code", int'(rdata[11:8]), m_mul);
      check("R6 invalid flag", int'(rdata[14]), exp_bad(m_src, m_mul));
    end
  end

  always @(sys_clk) begin
    if (mon_on && ($realtime - last_edge) < min_pulse) min_pulse = $realtime - last_edge;
    last_edge = $realtime;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_n = 1'b1;
    @(negedge clk_i);
    cmp_on = 1;
    check("R1 reset word", int'(rdata), 0);
    measure(20.0, "R1 reset clock period");
    mon_on = 1;

    // R6 invalid flag and R2 ignored codes
    wr(mk(0, 0, 0, 1, 7));
    check("R6 ext x9 valid", int'(rdata[14]), 0);
    wr(mk(0, 0, 0, 1, 8));
    check("R6 ext x10 invalid", int'(rdata[14]), 1);
    wr(mk(0, 0, 0, 2, 15));
    check("R6 ext/2 x16 valid", int'(rdata[14]), 0);
    wr(mk(3, 0, 0, 3, 7));
    check("R2 sel code 3 ignored", int'(rdata[1:0]), 0);
    check("R2 input code 3 ignored", int'(rdata[7:6]), 2);

    // R3 held request
    wr(mk(1, 0, 0, 2, 7));
    repeat (30) @(negedge clk_i);
    check("R3 held without enable", int'(rdata[3:2]), 0);
    check("R10 pending while held", int'(rdata[15]), 1);
    wr(mk(1, 1, 0, 2, 7));
    repeat (30) @(negedge clk_i);
    check("R3 held without ready", int'(rdata[3:2]), 0);
    ext_rdy = 1'b1;
    wait_status(1, "R5 switch to external");
    m_use = 1;
    measure(30.0, "R5 external period");
    check("R10 pending cleared", int'(rdata[15]), 0);
    check("R2 ext ready bit", int'(rdata[12]), 1);

    // R8 external kept on while active
    wr(mk(1, 0, 0, 2, 7));
    check("R8 ext disable ignored", int'(rdata[4]), 1);

    // R4 held multiplier request
    wr(mk(2, 1, 1, 1, 7));
    repeat (30) @(negedge clk_i);
    check("R4 held without ready", int'(rdata[3:2]), 1);
    pll_rdy = 1'b1;
    wait_status(2, "R5 switch to multiplier");
    m_use = 2;
    measure(8.0, "R5 multiplier period");
    check("R5 status encoding", int'(rdata & 16'h000C), 8);

    // R7 and R8 while multiplier active
    wr(mk(2, 0, 0, 2, 3));
    check("R8 pll disable ignored", int'(rdata[5]), 1);
    check("R8 feeding ext disable ignored", int'(rdata[4]), 1);
    check("R7 factor frozen", int'(rdata[11:8]), 7);
    measure(8.0, "R8 clock kept");

    // back to internal, then release
    wr(mk(0, 1, 1, 1, 7));
    wait_status(0, "R5 switch to internal");
    m_use = 0;
    measure(20.0, "R5 internal period");
    wr(mk(0, 0, 0, 2, 3));
    check("R8 pll disable accepted", int'(rdata[5]), 0);
    check("R7 write with disable ignored", int'(rdata[7:6]), 1);
    wr(mk(0, 0, 0, 2, 3));
    check("R7 write accepted when off", int'(rdata[11:8]), 3);

    // R4 disabled multiplier with ready still high
    wr(mk(2, 0, 0, 2, 3));
    repeat (30) @(negedge clk_i);
    check("R4 held without enable", int'(rdata[3:2]), 0);

    total++;
    if (min_pulse < 3.99) begin
      bad++;
      $display("FAIL R9 shortest phase actual=%0.2f expected=4.00", min_pulse);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule